// File: doc/BRIEF.md
# Dual-Lane 64-bit Table Keystream Core

This block produces a 64-bit keystream from two independently initialized 32-bit instances of a table-driven stream cipher that keeps two 512-entry tables, called P and Q here. The two instances are merged word by word into a single state: every 64-bit table entry carries instance 1's word in its upper half and instance 2's word in its lower half. After merging, the block updates the state with true 64-bit rotate, XOR and add operations and byte-indexed lookups, and produces one 64-bit keystream word per step.

Each table is kept as a pair of 32-bit RAM lanes (upper and lower) that are always read and written in the same cycle. Before generation starts, software or a preceding initialization engine writes every entry of both tables through a load port. A start pulse then begins free-running generation at one word every four clock cycles. Generation continues until reset. Initialization of the individual instances is not part of this block.

Top module: `wide_ks_core`

## Requirements
- R1: During and after reset, until the first step completes, `ks_valid_o` is 0 and `ks_data_o` is 0.
- R2: While the core is idle, a cycle with `load_en_i`=1 writes `load_data_i` into entry `load_addr_i` of table P (`load_tab_i`=0) or Q (`load_tab_i`=1). Bits 63:32 hold instance 1's word and bits 31:0 hold instance 2's word.
- R3: `start_i` is ignored until 1024 load writes have been made since reset. `start_i` is also ignored once generation is running, and running never stops before reset.
- R4: The first `ks_valid_o` pulse is one cycle wide and appears 4 clock edges after the edge that accepts `start_i`. After that, there is exactly one pulse every 4 cycles.
- R5: Step n (counted from 0) uses j = n mod 512. For (n mod 1024) < 512, P[j] becomes P[j] + (((P[j-3] rotr 10) ^ (P[j-511] rotr 23)) + (P[j-10] rotr 8)), with indices taken modulo 512. The output word is h(P[j-12]) ^ the new P[j], where h(w) = Q[w[7:0]] + Q[256 + w[55:48]].
- R6: For (n mod 1024) >= 512, the roles swap. Q[j] is updated the same way but with left rotations. The output word is Q-side h ^ the new Q[j], where the lookup is P[w[7:0]] + P[256 + w[55:48]].
- R7: All additions are modulo 2^64, so a carry out of bit 31 propagates into bit 32. The second lookup uses byte 6 (bits 55:48), not byte 2.
- R8: Table updates persist, so from step 1024 onward the second pass works on the entries rewritten by the first pass.
- R9: Load writes presented while generation is running have no effect on the tables.
- R10: `ks_data_o` holds its value between `ks_valid_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_en_i | input | 1 | Write one table entry this cycle |
| load_tab_i | input | 1 | Target table: 0 = P, 1 = Q |
| load_addr_i | input | 9 | Entry index |
| load_data_i | input | 64 | Merged entry {instance 1 word, instance 2 word} |
| start_i | input | 1 | Begin keystream generation |
| ks_valid_o | output | 1 | One-cycle strobe marking a new keystream word |
| ks_data_o | output | 64 | Keystream word |

## Verification
The main stimulus is a pair of fully random tables run for more than 1024 steps. This covers the P-update half, the Q-update half and the second pass over rewritten entries, and so it separates errors in rotation direction, neighbour offsets, table selection and state persistence. While generation runs, random load writes and extra start pulses are applied; any leak of these into the state would corrupt every later word. A directed run with every lower lane set to all ones and small upper lanes forces carries across bit 31. This exposes any datapath that adds the halves separately or indexes with the wrong byte. Start pulses issued before the last load write, the latency to the first word, the gaps between strobes, and the output between strobes are checked at the ports.

// File: rtl/wide_ks_pkg.sv
package wide_ks_pkg;
  localparam int TAB_DEPTH   = 512;
  localparam int TAB_AW      = $clog2(TAB_DEPTH);
  localparam int OFF_NEAR    = 3;
  localparam int OFF_MID     = 10;
  localparam int OFF_FAR     = 511;
  localparam int OFF_SEL     = 12;
  localparam int LOOKUP_BASE = 256;
  localparam int STEP_PHASES = 4;
endpackage

// File: rtl/ks_lane_ram.sv
module ks_lane_ram #(
  parameter int DEPTH  = 512,
  parameter int LANE_W = 32,
  parameter int N_LANE = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int WW    = LANE_W * N_LANE
) (
  input  logic          clk_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic          we_i,
  input  logic [AW-1:0] w_addr_i,
  input  logic [WW-1:0] w_data_i,
  output logic [WW-1:0] a_data_o,
  output logic [WW-1:0] b_data_o
);
  // one 32-bit memory per lane, all lanes share address and enable
  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_a_q, rd_b_q;

    always_ff @(posedge clk_i) begin
      if (we_i) mem[w_addr_i] <= w_data_i[l*LANE_W +: LANE_W];
      rd_a_q <= mem[a_addr_i];
      rd_b_q <= mem[b_addr_i];
    end

    assign a_data_o[l*LANE_W +: LANE_W] = rd_a_q;
    assign b_data_o[l*LANE_W +: LANE_W] = rd_b_q;
  end
endmodule

// File: rtl/ks_seq.sv
module ks_seq #(
  parameter int DEPTH  = 512,
  parameter int PHASES = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(PHASES),
  localparam int CW    = AW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic          start_i,
  output logic          loaded_o,
  output logic          running_o,
  output logic [PW-1:0] phase_o,
  output logic [AW:0]   step_o
);
  localparam int LOAD_NEED = 2 * DEPTH;

  logic [CW-1:0] load_cnt_q;
  logic          running_q;
  logic [PW-1:0] phase_q;
  logic [AW:0]   step_q;

  assign loaded_o  = (load_cnt_q == CW'(LOAD_NEED));
  assign running_o = running_q;
  assign phase_o   = phase_q;
  assign step_o    = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_cnt_q <= '0;
      running_q  <= 1'b0;
      phase_q    <= '0;
      step_q     <= '0;
    end else if (!running_q) begin
      if (load_en_i && !loaded_o) load_cnt_q <= load_cnt_q + 1'b1;
      if (start_i && loaded_o) begin
        running_q <= 1'b1;
        phase_q   <= '0;
        step_q    <= '0;
      end
    end else begin
      phase_q <= phase_q + 1'b1;
      if (phase_q == PW'(PHASES - 1)) step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/ks_mix_alu.sv
module ks_mix_alu #(
  parameter int WORD_W = 64
) (
  input  logic              use_left_i,
  input  logic [WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] z_i,
  input  logic [WORD_W-1:0] hsum_i,
  output logic [WORD_W-1:0] new_o,
  output logic [WORD_W-1:0] ks_o
);
  localparam int ROT_X = 10;
  localparam int ROT_Z = 23;
  localparam int ROT_Y = 8;

  function automatic logic [WORD_W-1:0] rot_r(input logic [WORD_W-1:0] v, input int s);
    return (v >> s) | (v << (WORD_W - s));
  endfunction

  function automatic logic [WORD_W-1:0] rot_l(input logic [WORD_W-1:0] v, input int s);
    return (v << s) | (v >> (WORD_W - s));
  endfunction

  logic [WORD_W-1:0] mix;

  always_comb begin
    if (use_left_i) mix = (rot_l(x_i, ROT_X) ^ rot_l(z_i, ROT_Z)) + rot_l(y_i, ROT_Y);
    else            mix = (rot_r(x_i, ROT_X) ^ rot_r(z_i, ROT_Z)) + rot_r(y_i, ROT_Y);
  end

  assign new_o = cur_i + mix;
  assign ks_o  = hsum_i ^ new_o;
endmodule

// File: rtl/wide_ks_core.sv
module wide_ks_core
  import wide_ks_pkg::*;
#(
  parameter int N_INST = 2,
  parameter int LANE_W = 32,
  localparam int WORD_W = N_INST * LANE_W,
  localparam int AW     = TAB_AW,
  localparam int SEC_BYTE = 4 * (N_INST - 1) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              load_tab_i,
  input  logic [AW-1:0]     load_addr_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              start_i,
  output logic              ks_valid_o,
  output logic [WORD_W-1:0] ks_data_o
);
  localparam int PW = $clog2(STEP_PHASES);

  logic          loaded, running;
  logic [PW-1:0] phase;
  logic [AW:0]   step;

  ks_seq #(.DEPTH(TAB_DEPTH), .PHASES(STEP_PHASES)) seq_i (
    .clk_i, .rst_ni, .load_en_i, .start_i,
    .loaded_o(loaded), .running_o(running), .phase_o(phase), .step_o(step)
  );

  logic          own_q_tab;
  logic [AW-1:0] j;
  assign own_q_tab = step[AW];
  assign j         = step[AW-1:0];

  logic [AW-1:0]     own_a_addr, own_b_addr, oth_a_addr, oth_b_addr;
  logic [WORD_W-1:0] p_a, p_b, q_a, q_b;
  logic [WORD_W-1:0] own_a, own_b, oth_a, oth_b;

  assign own_a = own_q_tab ? q_a : p_a;
  assign own_b = own_q_tab ? q_b : p_b;
  assign oth_a = own_q_tab ? p_a : q_a;
  assign oth_b = own_q_tab ? p_b : q_b;

  // own-table read schedule: ph0 {j-12, j}, ph1 {j-3, j-10}, ph2 {-, j-511}
  always_comb begin
    own_a_addr = j;
    own_b_addr = j;
    unique case (phase)
      PW'(0): begin own_a_addr = j - AW'(OFF_SEL);  own_b_addr = j; end
      PW'(1): begin own_a_addr = j - AW'(OFF_NEAR); own_b_addr = j - AW'(OFF_MID); end
      PW'(2): begin own_a_addr = j;                 own_b_addr = j - AW'(OFF_FAR); end
      default: ;
    endcase
  end

  // byte lookups driven in ph1 from the entry j-12 returned by ph0
  assign oth_a_addr = AW'(own_a[7:0]);
  assign oth_b_addr = AW'(LOOKUP_BASE) + AW'(own_a[SEC_BYTE*8 +: 8]);

  logic              step_we, load_we, p_we, q_we;
  logic [AW-1:0]     w_addr;
  logic [WORD_W-1:0] w_data, new_word, ks_word;

  assign step_we = running && (phase == PW'(STEP_PHASES - 1));
  assign load_we = load_en_i && !running;
  assign p_we    = (step_we && !own_q_tab) || (load_we && !load_tab_i);
  assign q_we    = (step_we &&  own_q_tab) || (load_we &&  load_tab_i);
  assign w_addr  = step_we ? j : load_addr_i;
  assign w_data  = step_we ? new_word : load_data_i;

  ks_lane_ram #(.DEPTH(TAB_DEPTH), .LANE_W(LANE_W), .N_LANE(N_INST)) p_ram_i (
    .clk_i,
    .a_addr_i(own_q_tab ? oth_a_addr : own_a_addr),
    .b_addr_i(own_q_tab ? oth_b_addr : own_b_addr),
    .we_i(p_we), .w_addr_i(w_addr), .w_data_i(w_data),
    .a_data_o(p_a), .b_data_o(p_b)
  );

  ks_lane_ram #(.DEPTH(TAB_DEPTH), .LANE_W(LANE_W), .N_LANE(N_INST)) q_ram_i (
    .clk_i,
    .a_addr_i(own_q_tab ? own_a_addr : oth_a_addr),
    .b_addr_i(own_q_tab ? own_b_addr : oth_b_addr),
    .we_i(q_we), .w_addr_i(w_addr), .w_data_i(w_data),
    .a_data_o(q_a), .b_data_o(q_b)
  );

  logic [WORD_W-1:0] cur_q, x_q, y_q, h_q, ks_q;
  logic              valid_q;

  ks_mix_alu #(.WORD_W(WORD_W)) alu_i (
    .use_left_i(own_q_tab), .cur_i(cur_q), .x_i(x_q), .y_i(y_q), .z_i(own_b),
    .hsum_i(h_q), .new_o(new_word), .ks_o(ks_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      h_q     <= '0;
      ks_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step_we;
      if (running && phase == PW'(1)) cur_q <= own_b;
      if (running && phase == PW'(2)) begin
        x_q <= own_a;
        y_q <= own_b;
        h_q <= oth_a + oth_b;
      end
      if (step_we) ks_q <= ks_word;
    end
  end

  assign ks_valid_o = valid_q;
  assign ks_data_o  = ks_q;
endmodule

// File: rtl/wide_ks_core_chk.sv
module wide_ks_core_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              loaded_i,
  input logic              running_i,
  input logic              ks_valid_i,
  input logic [WORD_W-1:0] ks_data_i
);
  a_r3_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_i && !loaded_i) |=> !running_i);

  a_r3_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> running_i);

  a_r4_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_i |-> (!$past(ks_valid_i, 1) && !$past(ks_valid_i, 2) && !$past(ks_valid_i, 3)));

  a_r4_valid_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_i |-> $past(running_i));

  a_r10_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ks_valid_i |-> $stable(ks_data_i));
endmodule

bind wide_ks_core wide_ks_core_chk #(.WORD_W(WORD_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .loaded_i(loaded), .running_i(running),
  .ks_valid_i(ks_valid_o), .ks_data_i(ks_data_o)
);

// File: tb/wide_ks_core_tb_top.sv
module wide_ks_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en_i = 1'b0;
  logic        load_tab_i = 1'b0;
  logic [8:0]  load_addr_i = '0;
  logic [63:0] load_data_i = '0;
  logic        start_i = 1'b0;
  logic        ks_valid_o;
  logic [63:0] ks_data_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [63:0] mp [512];
  logic [63:0] mq [512];

  always #2 clk_i = ~clk_i;

  wide_ks_core dut_i (.*);

  function automatic logic [63:0] rr(input logic [63:0] v, input int s);
    return (v >> s) | (v << (64 - s));
  endfunction

  function automatic logic [63:0] rl(input logic [63:0] v, input int s);
    return (v << s) | (v >> (64 - s));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference step from the requirement text
  task automatic model_step(input int n, output logic [63:0] ks);
    int j;
    logic [63:0] nw, w, h;
    j = n % 512;
    if ((n % 1024) < 512) begin
      nw = mp[j] + ((rr(mp[(j + 509) % 512], 10) ^ rr(mp[(j + 1) % 512], 23)) + rr(mp[(j + 502) % 512], 8));
      mp[j] = nw;
      w = mp[(j + 500) % 512];
      h = mq[w[7:0]] + mq[256 + int'(w[55:48])];
    end else begin
      nw = mq[j] + ((rl(mq[(j + 509) % 512], 10) ^ rl(mq[(j + 1) % 512], 23)) + rl(mq[(j + 502) % 512], 8));
      mq[j] = nw;
      w = mq[(j + 500) % 512];
      h = mp[w[7:0]] + mp[256 + int'(w[55:48])];
    end
    ks = h ^ nw;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 valid", 64'(ks_valid_o), 64'd0);
    chk("R1 data", ks_data_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic load_one(input bit tab, input int addr, input logic [31:0] w1, input logic [31:0] w2);
    load_en_i = 1'b1; load_tab_i = tab; load_addr_i = 9'(addr); load_data_i = {w1, w2};
    @(negedge clk_i);
    load_en_i = 1'b0;
  endtask

  // start at a negedge, check first-word latency, then run and compare
  task automatic run_words(input int nwords, input bit noise, input string tag);
    int got = 0, gap = 0, k = 0;
    logic [63:0] exp, last;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 1;
    while (!ks_valid_o && k < 20) begin @(negedge clk_i); k++; end
    chk("R4 first latency", 64'(k), 64'd5);
    while (got < nwords) begin
      if (ks_valid_o) begin
        if (got > 0) chk("R4 gap", 64'(gap), 64'd4);
        model_step(got, exp);
        chk(got < 512 ? {tag, " R5"} : (got < 1024 ? {tag, " R6"} : {tag, " R8"}), ks_data_o, exp);
        last = ks_data_o;
        got++;
        gap = 0;
      end else if (got > 0 && (gap == 2)) begin
        chk("R10 hold", ks_data_o, last);
      end
      // noise during run: loads and extra starts must have no effect (R9, R3)
      load_en_i   = noise && ($urandom_range(0, 3) == 0);
      load_tab_i  = 1'($urandom);
      load_addr_i = 9'($urandom);
      load_data_i = {$urandom, $urandom};
      start_i     = noise && ($urandom_range(0, 7) == 0);
      @(negedge clk_i);
      gap++;
    end
    load_en_i = 1'b0;
    start_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    do_reset();

    // random tables; withhold the last Q entry and try to start (R3)
    for (int i = 0; i < 512; i++) begin
      mp[i] = {$urandom, $urandom};
      mq[i] = {$urandom, $urandom};
    end
    for (int i = 0; i < 512; i++) load_one(1'b0, i, mp[i][63:32], mp[i][31:0]);
    for (int i = 0; i < 511; i++) load_one(1'b1, i, mq[i][63:32], mq[i][31:0]);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    begin
      int seen = 0;
      for (int c = 0; c < 16; c++) begin
        if (ks_valid_o) seen++;
        @(negedge clk_i);
      end
      chk("R3 start before load done", 64'(seen), 64'd0);
    end
    load_one(1'b1, 511, mq[511][63:32], mq[511][31:0]);
    run_words(1100, 1'b1, "R2 R9");

    // directed carry case: lower lanes all ones, small upper lanes (R7)
    do_reset();
    for (int i = 0; i < 512; i++) begin
      mp[i] = {32'($urandom_range(0, 255)) << ((i % 7) * 4), 32'hFFFF_FFFF};
      mq[i] = {32'($urandom), 32'hFFFF_FFFF};
    end
    for (int i = 0; i < 512; i++) load_one(1'b0, i, mp[i][63:32], mp[i][31:0]);
    for (int i = 0; i < 512; i++) load_one(1'b1, i, mq[i][63:32], mq[i][31:0]);
    run_words(600, 1'b0, "R7");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule